// File: doc/BRIEF.md
# SPI Digital Potentiometer Wiper Controller

This block is the digital core of a single-channel, 256-position potentiometer. A host drives it through a mode-0 SPI slave port. SDI is sampled on rising SCK, and SDO changes after falling SCK. The SCK, CS and SDI pins are brought into the system clock domain with two-flop synchronizers and edge detectors, so SCK must run well below the system clock. The block holds a 9-bit tap word, made of an 8-bit wiper position and an output-buffer enable bit. It also holds a four-slot non-volatile store, modelled as registers. Each write to the store takes a fixed, parameterised program time, and `busy_o` is high for that time.

Every frame is a command byte followed by a data byte, both sent MSB first. The command executes when CS rises. The block sits in a shift chain: bits received on SDI come out on SDO 16 SCK cycles later, so several parts can share one CS and each one keeps the last 16 bits it received. Readback commands load the response into the same shift register, so it is shifted out during the next frame. Slot 0 supplies the tap word at power-up and on the reset command. A write-protect input blocks writes to the store.

Top module: `dpot_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it is released, the tap word equals the power-up contents of slot 0, which is mid-scale (`tap_o` = 0x80) with `buf_en_o` = 0. `busy_o` and `sleep_o` are 0 and `sdo_oe_o` is 0.
- R2: The command byte is laid out as opcode in bits [7:4], store slot in bits [3:2] and channel in bits [1:0], and the data byte follows it. A frame executes on the CS rising edge only if the number of SCK rises is a non-zero multiple of 16, and only if the channel field is 00. Otherwise the tap word, the store and the sleep state are unchanged.
- R3: Opcode 0x4 sets the tap to the data byte and clears the buffer bit. Opcode 0xC sets the tap to the data byte and sets the buffer bit.
- R4: Opcode 0x6 increments the tap and opcode 0x8 decrements it. Both saturate at 0xFF and 0x00 and leave the buffer bit unchanged.
- R5: Opcode 0x5 writes {0, data} to the addressed slot and opcode 0xD writes {1, data}. Opcode 0x7 copies the current tap word into the addressed slot. An accepted store write raises `busy_o` for PROG_CYCLES clocks, and the slot takes the new word when `busy_o` falls.
- R6: While `wp_i` is 1, the store-write opcodes (0x5, 0xD, 0x7) are ignored: `busy_o` stays 0 and the slot keeps its contents.
- R7: A store-write opcode that arrives while `busy_o` is 1 is rejected, and the program cycle already in progress completes unchanged.
- R8: Opcode 0xB loads the tap word from the addressed slot.
- R9: Opcode 0x9 (addressed slot) and opcode 0xA (tap word) load the 16-bit response {7'b0, buffer bit, tap} into the shift register. The response is shifted out MSB first during the next frame.
- R10: SDO presents the bit received 16 SCK rises earlier, so a 32-bit frame executes its last 16 bits and shifts out its first 16. `sdo_oe_o` is 1 only while CS is low.
- R11: Opcode 0x2 sets `sleep_o`. If a program cycle is running, sleep is deferred until `busy_o` falls. While asleep, only wake (0x1) and reset (0x3) execute. Wake clears sleep and any deferred sleep request.
- R12: Opcode 0x3 reloads the tap word from the committed contents of slot 0, and clears sleep and any deferred sleep request.
- R13: Opcode 0x0 and the unused opcodes 0xE and 0xF have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| cs_ni | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI serial clock |
| sdi_i | input | 1 | SPI serial data in |
| wp_i | input | 1 | Write protect for the store, active high |
| sdo_o | output | 1 | SPI serial data out |
| sdo_oe_o | output | 1 | SDO drive enable (0 means high impedance) |
| tap_o | output | 8 | Wiper position |
| buf_en_o | output | 1 | Output-buffer mode bit |
| busy_o | output | 1 | Store program cycle in progress |
| sleep_o | output | 1 | Power-save state |

## Verification
A corrupted tap word shows on `tap_o` and `buf_en_o` three clocks after CS rises, and it also comes back in the next readback frame. A corrupted slot stays invisible until a recall or a readback of that slot; the bench therefore reads back or recalls every slot after writing it. Errors in the program-cycle counter show as a wrong `busy_o` length, or as a write that is accepted or lost in the wrong window. A wrong bit count or a wrong shift order corrupts the frame a neighbour in the chain receives one frame later, which the 32-bit chained frame exposes.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int CMD_W  = 8;
  localparam int SLOT_W = 2;
  localparam int CH_W   = 2;

  typedef enum logic [3:0] {
    OP_NOP      = 4'h0,
    OP_WAKE     = 4'h1,
    OP_SLEEP    = 4'h2,
    OP_RESET    = 4'h3,
    OP_WR_TAP   = 4'h4,
    OP_WR_NV    = 4'h5,
    OP_INC      = 4'h6,
    OP_SAVE     = 4'h7,
    OP_DEC      = 4'h8,
    OP_RD_NV    = 4'h9,
    OP_RD_TAP   = 4'hA,
    OP_RECALL   = 4'hB,
    OP_WR_TAP_B = 4'hC,
    OP_WR_NV_B  = 4'hD
  } op_e;
endpackage

// File: rtl/dpot_spi_rx.sv
module dpot_spi_rx #(
  parameter int FRAME_W = 16,
  parameter int SYNC_N  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sck_i,
  input  logic               sdi_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_data_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               frame_vld_o,
  output logic               sdo_o,
  output logic               sdo_oe_o
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [SYNC_N-1:0] cs_sync, sck_sync, sdi_sync;
  logic cs_q, sck_q;
  logic cs_s, sck_s, sdi_s;
  logic sck_rise, sck_fall, cs_fall, cs_rise;
  logic [CNT_W-1:0] cnt_q;
  logic full_q;
  logic [FRAME_W-1:0] shreg_q;
  logic sdo_q;

  // equal sync depth keeps SDI aligned with SCK
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sync  <= '1;
      sck_sync <= '0;
      sdi_sync <= '0;
      cs_q     <= 1'b1;
      sck_q    <= 1'b0;
    end else begin
      cs_sync  <= {cs_sync[SYNC_N-2:0], cs_ni};
      sck_sync <= {sck_sync[SYNC_N-2:0], sck_i};
      sdi_sync <= {sdi_sync[SYNC_N-2:0], sdi_i};
      cs_q     <= cs_s;
      sck_q    <= sck_s;
    end
  end

  assign cs_s  = cs_sync[SYNC_N-1];
  assign sck_s = sck_sync[SYNC_N-1];
  assign sdi_s = sdi_sync[SYNC_N-1];

  assign sck_rise = sck_s & ~sck_q & ~cs_s;
  assign sck_fall = ~sck_s & sck_q & ~cs_s;
  assign cs_fall  = ~cs_s & cs_q;
  assign cs_rise  = cs_s & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (cs_fall) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (sck_rise) begin
      if (cnt_q == CNT_W'(FRAME_W - 1)) begin
        cnt_q  <= '0;
        full_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shreg_q <= '0;
    else if (load_i) shreg_q <= load_data_i;
    else if (sck_rise) shreg_q <= {shreg_q[FRAME_W-2:0], sdi_s};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdo_q <= 1'b0;
    else if (cs_fall || sck_fall) sdo_q <= shreg_q[FRAME_W-1];
  end

  assign frame_o     = shreg_q;
  assign frame_vld_o = cs_rise & full_q & (cnt_q == '0);
  assign sdo_o       = sdo_q;
  assign sdo_oe_o    = ~cs_s;
endmodule

// File: rtl/dpot_nv_store.sv
module dpot_nv_store #(
  parameter int               WORD_W      = 9,
  parameter int               SLOTS       = 4,
  parameter int               PROG_CYCLES = 64,
  parameter logic [WORD_W-1:0] INIT0      = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [$clog2(SLOTS)-1:0] wr_slot_i,
  input  logic [WORD_W-1:0]        wr_word_i,
  input  logic [$clog2(SLOTS)-1:0] rd_slot_i,
  output logic [WORD_W-1:0]        rd_word_o,
  output logic [WORD_W-1:0]        slot0_o,
  output logic                     busy_o
);
  localparam int SA_W  = $clog2(SLOTS);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [WORD_W-1:0] mem_q [SLOTS];
  logic [CNT_W-1:0]  cnt_q;
  logic [SA_W-1:0]   pend_slot_q;
  logic [WORD_W-1:0] pend_word_q;
  logic              busy, accept, commit;

  assign busy   = (cnt_q != '0);
  assign accept = wr_i & ~busy;
  assign commit = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      pend_slot_q <= '0;
      pend_word_q <= '0;
    end else if (accept) begin
      cnt_q       <= CNT_W'(PROG_CYCLES);
      pend_slot_q <= wr_slot_i;
      pend_word_q <= wr_word_i;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // contents change only at the end of the program time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SLOTS; s++) mem_q[s] <= (s == 0) ? INIT0 : '0;
    end else if (commit) begin
      mem_q[pend_slot_q] <= pend_word_q;
    end
  end

  assign rd_word_o = mem_q[rd_slot_i];
  assign slot0_o   = mem_q[0];
  assign busy_o    = busy;
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
  import dpot_pkg::*;
#(
  parameter int                TAP_W       = 8,
  parameter int                NV_SLOTS    = 4,
  parameter int                PROG_CYCLES = 64,
  parameter logic [TAP_W:0]    NV_INIT0    = {2'b01, {(TAP_W-1){1'b0}}}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic             wp_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [TAP_W-1:0] tap_o,
  output logic             buf_en_o,
  output logic             busy_o,
  output logic             sleep_o
);
  localparam int WORD_W  = TAP_W + 1;
  localparam int FRAME_W = CMD_W + TAP_W;
  localparam int SA_W    = $clog2(NV_SLOTS);

  logic [FRAME_W-1:0] frame, load_data;
  logic               frame_vld, load;
  logic [CMD_W-1:0]   cmd;
  logic [3:0]         op;
  logic [SLOT_W-1:0]  slot;
  logic [CH_W-1:0]    ch;
  logic [TAP_W-1:0]   data;
  logic [WORD_W-1:0]  tap_q, tap_d, nv_rd_word, nv_slot0, nv_wr_word;
  logic               nv_wr, busy, run;
  logic               sleep_q, sleep_pend_q;

  dpot_spi_rx #(.FRAME_W(FRAME_W), .SYNC_N(2)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .sck_i       (sck_i),
    .sdi_i       (sdi_i),
    .load_i      (load),
    .load_data_i (load_data),
    .frame_o     (frame),
    .frame_vld_o (frame_vld),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
  );

  assign cmd  = frame[FRAME_W-1 -: CMD_W];
  assign data = frame[TAP_W-1:0];
  assign op   = cmd[7:4];
  assign slot = cmd[3:2];
  assign ch   = cmd[1:0];

  dpot_nv_store #(
    .WORD_W(WORD_W), .SLOTS(NV_SLOTS), .PROG_CYCLES(PROG_CYCLES), .INIT0(NV_INIT0)
  ) u_nv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (nv_wr),
    .wr_slot_i (slot[SA_W-1:0]),
    .wr_word_i (nv_wr_word),
    .rd_slot_i (slot[SA_W-1:0]),
    .rd_word_o (nv_rd_word),
    .slot0_o   (nv_slot0),
    .busy_o    (busy)
  );

  // asleep: only wake and reset get through
  assign run = frame_vld & (ch == '0) &
               (~sleep_q | (op == OP_WAKE) | (op == OP_RESET));

  always_comb begin
    tap_d      = tap_q;
    nv_wr      = 1'b0;
    nv_wr_word = tap_q;
    load       = 1'b0;
    load_data  = '0;
    if (run) begin
      case (op)
        OP_WR_TAP, OP_WR_TAP_B: tap_d = {op[3], data};
        OP_INC: if (tap_q[TAP_W-1:0] != '1) tap_d[TAP_W-1:0] = tap_q[TAP_W-1:0] + 1'b1;
        OP_DEC: if (tap_q[TAP_W-1:0] != '0) tap_d[TAP_W-1:0] = tap_q[TAP_W-1:0] - 1'b1;
        OP_RECALL: tap_d = nv_rd_word;
        OP_RESET:  tap_d = nv_slot0;
        OP_WR_NV, OP_WR_NV_B: begin
          nv_wr      = ~wp_i & ~busy;
          nv_wr_word = {op[3], data};
        end
        OP_SAVE: nv_wr = ~wp_i & ~busy;
        OP_RD_NV: begin
          load      = 1'b1;
          load_data = FRAME_W'(nv_rd_word);
        end
        OP_RD_TAP: begin
          load      = 1'b1;
          load_data = FRAME_W'(tap_q);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= NV_INIT0;
    else         tap_q <= tap_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q      <= 1'b0;
      sleep_pend_q <= 1'b0;
    end else begin
      if (sleep_pend_q && !busy) begin
        sleep_q      <= 1'b1;
        sleep_pend_q <= 1'b0;
      end
      if (run) begin
        case (op)
          OP_SLEEP: begin
            if (busy) sleep_pend_q <= 1'b1;
            else      sleep_q      <= 1'b1;
          end
          OP_WAKE, OP_RESET: begin
            sleep_q      <= 1'b0;
            sleep_pend_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign tap_o    = tap_q[TAP_W-1:0];
  assign buf_en_o = tap_q[TAP_W];
  assign busy_o   = busy;
  assign sleep_o  = sleep_q;
endmodule

// File: rtl/dpot_ctrl_chk.sv
module dpot_ctrl_chk
  import dpot_pkg::*;
#(
  parameter int TAP_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             wp_i,
  input logic             sdo_oe_i,
  input logic [TAP_W-1:0] tap_i,
  input logic             buf_i,
  input logic             busy_i,
  input logic             sleep_i,
  input logic             frame_vld_i,
  input logic [3:0]       op_i
);
  // R2
  tap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_vld_i) |-> ($stable(tap_i) && $stable(buf_i)));

  // R4
  inc_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(frame_vld_i) && ($past(op_i) == OP_INC) && ($past(tap_i) == '1)) |-> (tap_i == '1));

  // R4
  dec_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(frame_vld_i) && ($past(op_i) == OP_DEC) && ($past(tap_i) == '0)) |-> (tap_i == '0));

  // R6
  wp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !$past(wp_i));

  // R11
  sleep_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_i) |-> !$past(busy_i));

  // R10
  sdo_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_ni, 2) && $past(cs_ni)) |-> !sdo_oe_i);
endmodule

bind dpot_ctrl dpot_ctrl_chk #(.TAP_W(TAP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .wp_i        (wp_i),
  .sdo_oe_i    (sdo_oe_o),
  .tap_i       (tap_o),
  .buf_i       (buf_en_o),
  .busy_i      (busy_o),
  .sleep_i     (sleep_o),
  .frame_vld_i (frame_vld),
  .op_i        (op)
);

// File: tb/tb_dpot_ctrl.sv
module tb_dpot_ctrl;
  localparam int HALF = 6;
  localparam int PROG = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, wp = 1'b0;
  logic sdo, sdo_oe, buf_en, busy, sleep;
  logic [7:0] tap;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit oe_seen;

  always #5 clk = ~clk;

  dpot_ctrl #(.PROG_CYCLES(PROG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi), .wp_i(wp),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .tap_o(tap), .buf_en_o(buf_en),
    .busy_o(busy), .sleep_o(sleep)
  );

  // {cmd, data, exp_tap, exp_buf}
  localparam logic [24:0] VEC [12] = '{
    {8'h40, 8'h12, 8'h12, 1'b0},  // R3
    {8'h60, 8'h00, 8'h13, 1'b0},  // R4
    {8'h80, 8'h00, 8'h12, 1'b0},  // R4
    {8'hC0, 8'hFE, 8'hFE, 1'b1},  // R3
    {8'h60, 8'h00, 8'hFF, 1'b1},  // R4
    {8'h60, 8'h00, 8'hFF, 1'b1},  // R4 saturate high
    {8'h40, 8'h01, 8'h01, 1'b0},  // R3
    {8'h80, 8'h00, 8'h00, 1'b0},  // R4
    {8'h80, 8'h00, 8'h00, 1'b0},  // R4 saturate low
    {8'h41, 8'h55, 8'h00, 1'b0},  // R2 channel field nonzero
    {8'hF0, 8'h77, 8'h00, 1'b0},  // R13 unused opcode
    {8'h00, 8'h99, 8'h00, 1'b0}   // R13 nop
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] bits, input int n, output logic [31:0] rx);
    rx = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      repeat (HALF) @(negedge clk);
      rx = {rx[30:0], sdo};
      oe_seen &= sdo_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] c, input logic [7:0] d);
    logic [31:0] rx;
    xfer({16'h0, c, d}, 16, rx);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_tap(input string req, input logic [7:0] et, input logic eb);
    chk(req, {23'h0, buf_en, tap}, {23'h0, eb, et});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 act=timeout exp=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rx;
    repeat (4) @(negedge clk);
    // R1 state during reset and after release
    chk_tap("R1", 8'h80, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_tap("R1", 8'h80, 1'b0);
    chk("R1", {busy, sleep, sdo_oe}, 3'b000);

    for (int v = 0; v < 12; v++) begin
      frame(VEC[v][24:17], VEC[v][16:9]);
      chk_tap($sformatf("R2/R3/R4/R13 vec%0d", v), VEC[v][8:1], VEC[v][0]);
    end

    // R5 direct store write slot1 with buffer bit, then R8 recall
    frame(8'hD4, 8'h3C);
    chk("R5", {31'h0, busy}, 1);
    wait_idle();
    chk("R5", {31'h0, busy}, 0);
    frame(8'hB4, 8'h00);
    chk_tap("R8", 8'h3C, 1'b1);

    // R9 store readback
    frame(8'h94, 8'h00);
    xfer(32'h0, 16, rx);
    chk("R9", rx, 32'h013C);

    // R9 tap readback, R10 drive enable
    frame(8'h40, 8'hA5);
    frame(8'hA0, 8'h00);
    oe_seen = 1'b1;
    xfer(32'h0, 16, rx);
    chk("R9", rx, 32'h00A5);
    chk("R10", {31'h0, oe_seen}, 1);
    chk("R10", {31'h0, sdo_oe}, 0);

    // R5 save tap into slot2
    frame(8'h78, 8'h00);
    wait_idle();
    frame(8'h40, 8'h00);
    frame(8'hB8, 8'h00);
    chk_tap("R5", 8'hA5, 1'b0);

    // R6 write protect
    frame(8'h40, 8'h44);
    wp = 1'b1;
    frame(8'hDC, 8'h11);
    chk("R6", {31'h0, busy}, 0);
    wp = 1'b0;
    frame(8'hBC, 8'h00);
    chk_tap("R6", 8'h00, 1'b0);

    // R7 write during busy rejected
    frame(8'h54, 8'h22);
    frame(8'hD4, 8'h99);
    chk("R7", {31'h0, busy}, 1);
    wait_idle();
    frame(8'hB4, 8'h00);
    chk_tap("R7", 8'h22, 1'b0);

    // R11 deferred sleep, gating, wake
    frame(8'h50, 8'h10);
    frame(8'h20, 8'h00);
    chk("R11", {30'h0, busy, sleep}, 2'b10);
    wait_idle();
    chk("R11", {31'h0, sleep}, 1);
    frame(8'h40, 8'h77);
    chk_tap("R11", 8'h22, 1'b0);
    frame(8'h10, 8'h00);
    chk("R11", {31'h0, sleep}, 0);
    frame(8'h40, 8'h77);
    chk_tap("R11", 8'h77, 1'b0);

    // R12 reset command from sleep
    frame(8'h20, 8'h00);
    chk("R11", {31'h0, sleep}, 1);
    frame(8'h30, 8'h00);
    chk_tap("R12", 8'h10, 1'b0);
    chk("R12", {31'h0, sleep}, 0);

    // R2 wrong bit counts
    xfer(32'h0000_40AB, 15, rx);
    chk_tap("R2", 8'h10, 1'b0);
    xfer(32'h0001_40AB, 17, rx);
    chk_tap("R2", 8'h10, 1'b0);

    // R10 chained 32-bit frame
    xfer({16'h4033, 16'h405A}, 32, rx);
    chk_tap("R10", 8'h5A, 1'b0);
    chk("R10", {16'h0, rx[15:0]}, 32'h4033);

    // R13 unused opcode
    frame(8'hE0, 8'h12);
    chk_tap("R13", 8'h5A, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule